// File: doc/BRIEF.md
# Receive FIFO Read Index Tracker

This block keeps the read position of a receive queue whose entries are message buffers in a shared header table. Software programs the header number of the queue's first entry, the number of entries and the payload size of each entry. The block then reports the header number of the oldest unread entry. It also keeps a count of unread entries, which rises on each receive-side push strobe.

When the host has consumed entries, it acknowledges them through the register port. A mode bit selects how the acknowledge works. In single-step mode, writing a flag register releases one entry. In counted mode, the host writes a pop count and that many entries are released. A pop never releases more entries than are unread. The index wraps from the last entry of the ring back to the first one.

The geometry and mode registers can be changed only while the configuration-state input is high. Any accepted change to the start or geometry register reloads the index with the start value and empties the count. Register reads return data one cycle after the address is presented.

Top module: `rxq_rdidx_tracker`

## Requirements
- R1: After a synchronous reset, every register reads zero, `rd_idx_o` is zero and the unread count is zero.
- R2: The geometry register at address 1 holds the entry count in bits [15:8] and the payload size in 2-byte units in bits [6:0], and bit 7 reads zero. A write to it takes effect only while `cfg_state_i` is 1; other writes are ignored.
- R3: The start register at address 0 (bits [9:0]) and the mode register at address 5 (bit 0; 0 selects single-step, 1 selects counted) accept writes only while `cfg_state_i` is 1. An accepted write to address 0 or address 1 loads the read index with the start value and clears the unread count.
- R4: Address 2 reads the read index in bits [9:0] with bits [15:10] zero. `rd_idx_o` carries the same value.
- R5: In single-step mode, writing address 4 with bit 0 set releases one entry when at least one entry is unread. Writes to address 3 have no effect on the index or the count.
- R6: In counted mode, writing address 3 releases the number of entries given in bits [7:0]. Writes to address 4 have no effect.
- R7: The number of entries released is limited to the current unread count, so the index never moves past unread data.
- R8: The index moves forward by the number of entries released, modulo the entry count. After start + depth − 1 it continues at start.
- R9: Each push strobe raises the unread count by one, and the count saturates at the entry count. Address 3 reads the count in bits [7:0].
- R10: When a push and a pop fall in the same cycle, the count changes by their net effect. The push is accepted when the count left after the pop is below the entry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_state_i | input | 1 | Controller is in its configuration state |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for writes and reads |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data for the address of the previous cycle |
| push_i | input | 1 | Receive side has stored one entry |
| rd_idx_o | output | 16 | Header index of the next entry to read |

## Verification
A receive push and a host pop can land in the same clock cycle, and both then act on the unread count. The bench drives the push strobe together with pop writes in both modes: with the queue partly filled, with it full, and with a pop count larger than the unread count. It judges the result by reading the count and the index back and comparing them, on every clock, against a behavioural model in which the pop is taken first and the push is accepted against the remainder. Configuration reloads are also issued while pushes are pending, to confirm that the reload wins.

// File: rtl/rfx_pkg.sv
package rfx_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_START  = 3'd0;
  localparam logic [ADDR_W-1:0] A_GEOM   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RDIDX  = 3'd2;
  localparam logic [ADDR_W-1:0] A_POPCNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd4;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd5;

  typedef enum logic {
    POP_SINGLE = 1'b0,
    POP_COUNT  = 1'b1
  } pop_mode_e;
endpackage

// File: rtl/rfx_cfg_regs.sv
module rfx_cfg_regs
  import rfx_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int DEPTH_W = 8,
  parameter int SIZE_W  = 7,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_state_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [IDX_W-1:0]   start_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic [SIZE_W-1:0]  size_o,
  output pop_mode_e          mode_o,
  output logic               reload_o,
  output logic [IDX_W-1:0]   load_idx_o
);
  localparam int DEPTH_LSB = DATA_W / 2;

  logic wr_ok, wr_start, wr_geom, wr_mode;

  assign wr_ok    = wr_i & cfg_state_i;
  assign wr_start = wr_ok && (addr_i == A_START);
  assign wr_geom  = wr_ok && (addr_i == A_GEOM);
  assign wr_mode  = wr_ok && (addr_i == A_MODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o <= '0;
      depth_o <= '0;
      size_o  <= '0;
      mode_o  <= POP_SINGLE;
    end else begin
      if (wr_start) start_o <= wdata_i[IDX_W-1:0];
      if (wr_geom) begin
        depth_o <= wdata_i[DEPTH_LSB +: DEPTH_W];
        size_o  <= wdata_i[SIZE_W-1:0];
      end
      if (wr_mode) mode_o <= pop_mode_e'(wdata_i[0]);
    end
  end

  assign reload_o   = wr_start | wr_geom;
  assign load_idx_o = wr_start ? wdata_i[IDX_W-1:0] : start_o;
endmodule

// File: rtl/rfx_pop_ctrl.sv
module rfx_pop_ctrl #(
  parameter int DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reload_i,
  input  logic               push_i,
  input  logic               pop_req_i,
  input  logic [DEPTH_W-1:0] pop_cnt_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [DEPTH_W-1:0] fill_o,
  output logic [DEPTH_W-1:0] pop_n_o
);
  logic [DEPTH_W-1:0] after_pop;
  logic               push_ok;

  always_comb begin
    pop_n_o = '0;
    if (pop_req_i) pop_n_o = (pop_cnt_i > fill_o) ? fill_o : pop_cnt_i;
    after_pop = fill_o - pop_n_o;
    push_ok   = push_i && (after_pop < depth_i);
  end

  always_ff @(posedge clk) begin
    if (rst || reload_i) fill_o <= '0;
    else                 fill_o <= after_pop + DEPTH_W'(push_ok);
  end
endmodule

// File: rtl/rfx_idx_adv.sv
module rfx_idx_adv #(
  parameter int IDX_W   = 10,
  parameter int DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reload_i,
  input  logic [IDX_W-1:0]   load_idx_i,
  input  logic [IDX_W-1:0]   start_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [DEPTH_W-1:0] step_i,
  output logic [IDX_W-1:0]   idx_o
);
  localparam int SUM_W = IDX_W + 1;

  logic [IDX_W-1:0] offset;
  logic [SUM_W-1:0] sum, depth_x, wrapped;

  always_comb begin
    offset  = idx_o - start_i;
    depth_x = SUM_W'(depth_i);
    sum     = {1'b0, offset} + SUM_W'(step_i);
    wrapped = (sum >= depth_x) ? (sum - depth_x) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst)                              idx_o <= '0;
    else if (reload_i)                    idx_o <= load_idx_i;
    else if (step_i != '0 && depth_i != '0) idx_o <= start_i + wrapped[IDX_W-1:0];
  end
endmodule

// File: rtl/rxq_rdidx_tracker.sv
module rxq_rdidx_tracker
  import rfx_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int DEPTH_W = 8,
  parameter int SIZE_W  = 7,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_state_i,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              push_i,
  output logic [DATA_W-1:0] rd_idx_o
);
  localparam int DEPTH_LSB = DATA_W / 2;

  logic [IDX_W-1:0]   start_q, load_idx, idx_q;
  logic [DEPTH_W-1:0] depth_q, fill_q, pop_cnt, pop_n;
  logic [SIZE_W-1:0]  size_q;
  pop_mode_e          mode_q;
  logic               reload, pop_req;
  logic [DATA_W-1:0]  rd_mux;

  rfx_cfg_regs #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_state_i(cfg_state_i), .wr_i(reg_wr_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .start_o(start_q),
    .depth_o(depth_q), .size_o(size_q), .mode_o(mode_q),
    .reload_o(reload), .load_idx_o(load_idx)
  );

  always_comb begin
    pop_req = 1'b0;
    pop_cnt = '0;
    if (reg_wr_i) begin
      if (mode_q == POP_SINGLE && reg_addr_i == A_FLAG && reg_wdata_i[0]) begin
        pop_req = 1'b1;
        pop_cnt = DEPTH_W'(1);
      end else if (mode_q == POP_COUNT && reg_addr_i == A_POPCNT) begin
        pop_req = 1'b1;
        pop_cnt = reg_wdata_i[DEPTH_W-1:0];
      end
    end
  end

  rfx_pop_ctrl #(.DEPTH_W(DEPTH_W)) u_pop (
    .clk(clk), .rst(rst), .reload_i(reload), .push_i(push_i),
    .pop_req_i(pop_req), .pop_cnt_i(pop_cnt), .depth_i(depth_q),
    .fill_o(fill_q), .pop_n_o(pop_n)
  );

  rfx_idx_adv #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W)) u_idx (
    .clk(clk), .rst(rst), .reload_i(reload), .load_idx_i(load_idx),
    .start_i(start_q), .depth_i(depth_q), .step_i(pop_n), .idx_o(idx_q)
  );

  always_comb begin
    case (reg_addr_i)
      A_START:  rd_mux = DATA_W'(start_q);
      A_GEOM:   rd_mux = (DATA_W'(depth_q) << DEPTH_LSB) | DATA_W'(size_q);
      A_RDIDX:  rd_mux = DATA_W'(idx_q);
      A_POPCNT: rd_mux = DATA_W'(fill_q);
      A_MODE:   rd_mux = DATA_W'(mode_q == POP_COUNT);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else     reg_rdata_o <= rd_mux;
  end

  assign rd_idx_o = DATA_W'(idx_q);
endmodule

// File: rtl/rfx_tracker_chk.sv
module rfx_tracker_chk
  import rfx_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int DEPTH_W = 8,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_state_i,
  input logic               reg_wr_i,
  input logic [2:0]         reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic               push_i,
  input logic [IDX_W-1:0]   start_q,
  input logic [DEPTH_W-1:0] depth_q,
  input logic [DEPTH_W-1:0] fill_q,
  input logic [IDX_W-1:0]   idx_q,
  input pop_mode_e          mode_q,
  input logic               reload
);
  logic [IDX_W-1:0] off;
  assign off = idx_q - start_q;

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (rst)
    !cfg_state_i |=> $stable(depth_q) && $stable(start_q) && $stable(mode_q)); // R2

  AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    reload |=> (fill_q == '0) && (idx_q == start_q)); // R3

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == A_FLAG && reg_wdata_i[0] && mode_q == POP_SINGLE
     && fill_q != '0 && !push_i) |=> fill_q == $past(fill_q) - DEPTH_W'(1)); // R5

  AST_NO_OVERPOP: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == A_POPCNT && mode_q == POP_COUNT && !push_i
     && reg_wdata_i[DEPTH_W-1:0] >= fill_q) |=> fill_q == '0); // R7

  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (rst)
    (depth_q != '0) |-> off < IDX_W'(depth_q)); // R8

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_q <= depth_q); // R9
endmodule

bind rxq_rdidx_tracker rfx_tracker_chk #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_state_i(cfg_state_i), .reg_wr_i(reg_wr_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .push_i(push_i),
  .start_q(start_q), .depth_q(depth_q), .fill_q(fill_q), .idx_q(idx_q),
  .mode_q(mode_q), .reload(reload)
);

// File: tb/rxq_rdidx_tracker_tb.sv
`timescale 1ns/1ps
module rxq_rdidx_tracker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_state_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd2;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o, rd_idx_o;
  logic        push_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_start = 0, m_depth = 0, m_size = 0, m_mode = 0, m_fill = 0, m_idx = 0;
  int m_rdata = 0;

  always #2.5 clk = ~clk;

  rxq_rdidx_tracker u_dut (
    .clk(clk), .rst(rst), .cfg_state_i(cfg_state_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .push_i(push_i), .rd_idx_o(rd_idx_o)
  );

  function automatic int model_read(int a);
    case (a)
      0: return m_start;
      1: return (m_depth << 8) | m_size;
      2: return m_idx;
      3: return m_fill;
      5: return m_mode;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int n, a, d;
    a = int'(reg_addr_i);
    d = int'(reg_wdata_i);
    m_rdata = rst ? 0 : model_read(a);
    if (rst) begin
      m_start = 0; m_depth = 0; m_size = 0; m_mode = 0; m_fill = 0; m_idx = 0;
    end else if (reg_wr_i && cfg_state_i && a == 0) begin
      m_start = d & 1023; m_idx = m_start; m_fill = 0;
    end else if (reg_wr_i && cfg_state_i && a == 1) begin
      m_depth = (d >> 8) & 255; m_size = d & 127; m_idx = m_start; m_fill = 0;
    end else begin
      n = 0;
      if (reg_wr_i && m_mode == 0 && a == 4 && (d & 1) != 0) n = 1;
      if (reg_wr_i && m_mode == 1 && a == 3) n = d & 255;
      if (n > m_fill) n = m_fill;
      m_fill = m_fill - n;
      if (push_i && m_fill < m_depth) m_fill = m_fill + 1;
      if (n > 0 && m_depth > 0)
        m_idx = (m_start + ((((m_idx - m_start) & 1023) + n) % m_depth)) & 1023;
      if (reg_wr_i && cfg_state_i && a == 5) m_mode = d & 1;
    end
  end

  // model comparison on every clock (R4, R9 and all others through the model)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (int'(rd_idx_o) != m_idx || int'(reg_rdata_o) != m_rdata) begin
        errors++;
        $display("FAIL R4 model compare: idx=%0d rdata=%0h expected idx=%0d rdata=%0h",
                 rd_idx_o, reg_rdata_o, m_idx, m_rdata);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit wr, int addr, int data, bit push);
    reg_wr_i    = wr;
    reg_addr_i  = 3'(addr);
    reg_wdata_i = 16'(data);
    push_i      = push;
    @(posedge clk);
    @(negedge clk);
    reg_wr_i = 1'b0;
    push_i   = 1'b0;
    reg_addr_i = 3'd2;
  endtask

  task automatic rd(int addr, int exp, string req);
    reg_addr_i = 3'(addr);
    @(posedge clk);
    @(negedge clk);
    check(req, int'(reg_rdata_o), exp);
    reg_addr_i = 3'd2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idx after reset", int'(rd_idx_o), 0);
    rd(1, 0, "R1 geometry after reset");
    rd(3, 0, "R1 fill after reset");

    cfg_state_i = 1'b1;
    cyc(1, 0, 100, 0);
    cyc(1, 1, 16'h0405, 0);
    rd(1, 16'h0405, "R2 geometry readback");
    rd(2, 100, "R3 idx loaded with start");
    cyc(1, 1, 16'h0485, 0);
    rd(1, 16'h0405, "R2 bit7 reads zero");
    cfg_state_i = 1'b0;
    cyc(1, 1, 16'h0909, 0);
    rd(1, 16'h0405, "R2 write outside config ignored");
    cyc(1, 0, 7, 0);
    rd(0, 100, "R3 start write outside config ignored");

    repeat (3) cyc(0, 2, 0, 1);
    rd(3, 3, "R9 fill after three pushes");

    cyc(1, 4, 1, 0);
    check("R5 single step", int'(rd_idx_o), 101);
    cyc(1, 3, 2, 0);
    check("R5 count write ignored in single mode", int'(rd_idx_o), 101);
    cyc(1, 4, 2, 0);
    check("R5 flag without bit0 no effect", int'(rd_idx_o), 101);
    rd(3, 2, "R5 fill after single step");

    cfg_state_i = 1'b1;
    cyc(1, 5, 1, 0);
    cfg_state_i = 1'b0;
    rd(5, 1, "R3 mode readback");
    cyc(1, 3, 1, 0);
    check("R6 counted pop of one", int'(rd_idx_o), 102);
    cyc(1, 4, 1, 0);
    check("R6 flag ignored in counted mode", int'(rd_idx_o), 102);
    repeat (5) cyc(0, 2, 0, 1);
    rd(3, 4, "R9 fill saturates at depth");

    cyc(1, 3, 3, 0);
    check("R8 wrap to start", int'(rd_idx_o), 101);
    cyc(1, 3, 5, 0);
    check("R7 clamped pop index", int'(rd_idx_o), 102);
    rd(3, 0, "R7 fill after clamped pop");
    cyc(1, 3, 2, 0);
    check("R7 pop on empty no effect", int'(rd_idx_o), 102);

    cyc(0, 2, 0, 1);
    cyc(0, 2, 0, 1);
    cyc(1, 3, 1, 1);
    check("R10 push with pop idx", int'(rd_idx_o), 103);
    rd(3, 2, "R10 net fill push and pop");
    cyc(0, 2, 0, 1);
    cyc(0, 2, 0, 1);
    cyc(1, 3, 1, 1);
    check("R8 wrap while full", int'(rd_idx_o), 100);
    rd(3, 4, "R10 push accepted after pop when full");
    cyc(1, 3, 9, 1);
    rd(3, 1, "R10 clamped pop with push");

    cfg_state_i = 1'b1;
    cyc(1, 0, 1020, 1);
    rd(3, 0, "R3 reload clears fill");
    check("R4 idx after reload", int'(rd_idx_o), 1020);
    cfg_state_i = 1'b0;
    repeat (4) cyc(0, 2, 0, 1);
    cyc(1, 3, 3, 0);
    check("R8 top of index space", int'(rd_idx_o), 1023);
    cyc(1, 3, 1, 0);
    check("R8 wrap from top", int'(rd_idx_o), 1020);
    rd(2, 1020, "R4 index register");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule